// File: doc/BRIEF.md
# Link Command Framer and Checker

This block sits on a byte-wide symbol stream in which each symbol carries a flag marking it as a control (K) symbol or a data (D) symbol. It has a transmit half and a receive half that run on the same clock and are otherwise independent.

The transmit half takes an 11-bit command through a valid/ready handshake and computes a 5-bit CRC over it. It then emits a fixed eight-symbol frame: a four-symbol K start set, followed by the 16-bit command word sent twice. No delimiter marks the end of the frame; the start set alone implies its length.

The receive half examines every incoming symbol as a possible frame end. It does this with a sliding window over the last eight accepted symbols. A frame passes when enough of its start symbols match, both word copies are data symbols and CRC-clean, and the two copies are identical. It then raises a one-cycle pulse carrying the 11-bit command. Frames that fail are dropped silently, and the search resumes on the very next symbol.

Top module: `lcmd_link_top`

## Requirements
- R1: After a transmit handshake, `txSymValid` is high for exactly eight consecutive cycles, starting on the next cycle. The first four symbols are K symbols with bytes 0x5C, 0x5C, 0x5C, 0xF7, in that order.
- R2: Transmit symbols five to eight are D symbols. They carry the command word as high byte, low byte, and then the same two bytes again. The word puts the command in bits 15..5 and the CRC in bits 4..0.
- R3: The CRC uses generator x^5+x^2+1. It is computed over the command MSB first, with the register preset to all ones, and the result is inverted.
- R4: `txCmdReady` is high after reset and whenever no frame is being sent. A command is taken when `txCmdValid` and `txCmdReady` are both high. Ready stays low from the cycle after the handshake through the last symbol, and returns high on the cycle after that.
- R5: A receive frame with a correct start set and two identical, CRC-clean D-symbol words raises `cmdValid` for one cycle. The pulse comes on the cycle after the eighth symbol is taken, with `cmdOut` equal to the command bits.
- R6: A frame is still accepted when exactly one of its four start symbols is wrong, either in byte value or in K flag.
- R7: A frame with two or more wrong start symbols produces no pulse.
- R8: A frame whose two word copies are identical but fail the CRC produces no pulse.
- R9: A frame whose two word copies are each CRC-clean but differ produces no pulse.
- R10: A frame in which any of the four word symbols is flagged K produces no pulse.
- R11: After a rejected candidate, the search continues on the next symbol. Surplus start symbols, or a rejected frame, followed at once by a good frame still yield exactly one pulse for the good frame.
- R12: Cycles with `rxSymValid` low are ignored, whatever data or flag they carry, even in the middle of a frame. `cmdValid` is never high for two cycles in a row for one frame, and rejected frames produce no output at all.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txCmdValid | input | 1 | Transmit command offered |
| txCmdReady | output | 1 | Transmit command can be taken |
| txCmd | input | 11 | Command to frame |
| txSymValid | output | 1 | Transmit symbol present |
| txSymData | output | 8 | Transmit symbol byte |
| txSymIsK | output | 1 | Transmit symbol is a K symbol |
| rxSymValid | input | 1 | Receive symbol present |
| rxSymData | input | 8 | Receive symbol byte |
| rxSymIsK | input | 1 | Receive symbol is a K symbol |
| cmdValid | output | 1 | One-cycle pulse: command received |
| cmdOut | output | 11 | Received command |

## Verification
The bench uses the default start set 0x5C, 0x5C, 0x5C, 0xF7 with a match threshold of three. This makes the one-bad-symbol acceptance and the two-bad-symbol rejection both reachable. It also lets a run of surplus start symbols test that the search restarts on the next symbol. Random commands, random corruption modes and random stall cycles are mixed with directed overlap cases. The expected symbols and CRC come from a long-division reference.

// File: rtl/lcmd_pkg.sv
package lcmd_pkg;
  localparam int SYM_W     = 8;
  localparam int CMD_W     = 11;
  localparam int CRC_W     = 5;
  localparam int WORD_W    = CMD_W + CRC_W;
  localparam int WORD_SYMS = WORD_W / SYM_W;
  localparam int START_LEN = 4;
  localparam int COPIES    = 2;
  localparam int FRAME_LEN = START_LEN + COPIES * WORD_SYMS;
  localparam int HIST      = FRAME_LEN - 1;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int CNT_W     = $clog2(START_LEN + 1);

  localparam logic [CRC_W-1:0] CRC_POLY = 5'b00101;
  localparam logic [CRC_W-1:0] CRC_INIT = '1;

  typedef logic [IDX_W-1:0] symIdx_t;

  typedef struct packed {
    logic    txLoad;
    logic    txActive;
    symIdx_t txIdx;
    logic    rxShift;
    logic    rxCapture;
  } lcmdStrobes_t;

  function automatic logic [CRC_W-1:0] crcCalc(input logic [CMD_W-1:0] info);
    logic [CRC_W-1:0] r;
    logic fb;
    r = CRC_INIT;
    for (int i = CMD_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ info[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return ~r;
  endfunction
endpackage

// File: rtl/lcmd_ctrl.sv
module lcmd_ctrl
  import lcmd_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         txCmdValid,
  output logic         txCmdReady,
  input  logic         rxSymValid,
  input  logic         frameOk,
  output lcmdStrobes_t strb
);
  localparam symIdx_t LAST_IDX = symIdx_t'(FRAME_LEN - 1);

  logic    busy;
  symIdx_t idx;
  logic    accept;

  assign txCmdReady = !busy;
  assign accept     = txCmdValid && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      if (idx == LAST_IDX) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  always_comb begin
    strb           = '0;
    strb.txLoad    = accept;
    strb.txActive  = busy;
    strb.txIdx     = idx;
    strb.rxShift   = rxSymValid;
    strb.rxCapture = rxSymValid && frameOk;
  end

  // R4: a taken command blocks the next one on the following cycle
  assert_ready_drop_R4: assert property (@(posedge clk) disable iff (!rstN)
    (txCmdValid && txCmdReady) |=> !txCmdReady);

  // R1: a frame always begins at index zero right after the handshake
  assert_frame_start_R1: assert property (@(posedge clk) disable iff (!rstN)
    (txCmdValid && txCmdReady) |=> (strb.txActive && strb.txIdx == '0));
endmodule

// File: rtl/lcmd_datapath.sv
module lcmd_datapath
  import lcmd_pkg::*;
#(
  parameter logic [START_LEN*SYM_W-1:0] START_SET = 32'h5C5C5CF7,
  parameter int MIN_START_MATCH = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  lcmdStrobes_t     strb,
  input  logic [CMD_W-1:0] txCmd,
  output logic             txSymValid,
  output logic [SYM_W-1:0] txSymData,
  output logic             txSymIsK,
  input  logic [SYM_W-1:0] rxSymData,
  input  logic             rxSymIsK,
  output logic             frameOk,
  output logic             cmdValid,
  output logic [CMD_W-1:0] cmdOut
);
  // ---------------- transmit ----------------
  logic [WORD_W-1:0] txWord;
  logic [SYM_W-1:0]  txFrame  [FRAME_LEN];
  logic              txFrameK [FRAME_LEN];

  always_ff @(posedge clk) begin
    if (!rstN) txWord <= '0;
    else if (strb.txLoad) txWord <= {txCmd, crcCalc(txCmd)};
  end

  always_comb begin
    for (int g = 0; g < START_LEN; g++) begin
      txFrame[g]  = START_SET[(START_LEN-1-g)*SYM_W +: SYM_W];
      txFrameK[g] = 1'b1;
    end
    for (int c = 0; c < COPIES; c++) begin
      for (int b = 0; b < WORD_SYMS; b++) begin
        txFrame[START_LEN + c*WORD_SYMS + b]  = txWord[(WORD_SYMS-1-b)*SYM_W +: SYM_W];
        txFrameK[START_LEN + c*WORD_SYMS + b] = 1'b0;
      end
    end
  end

  assign txSymValid = strb.txActive;
  assign txSymData  = strb.txActive ? txFrame[strb.txIdx] : '0;
  assign txSymIsK   = strb.txActive && txFrameK[strb.txIdx];

  // ---------------- receive ----------------
  logic [SYM_W-1:0]  hist  [HIST];
  logic              histK [HIST];
  logic [SYM_W-1:0]  cand  [FRAME_LEN];
  logic              candK [FRAME_LEN];

  for (genvar i = 0; i < FRAME_LEN; i++) begin : g_cand
    if (i < HIST) begin : g_old
      assign cand[i]  = hist[i];
      assign candK[i] = histK[i];
    end else begin : g_new
      assign cand[i]  = rxSymData;
      assign candK[i] = rxSymIsK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < HIST; i++) begin
        hist[i]  <= '0;
        histK[i] <= 1'b0;
      end
    end else if (strb.rxShift) begin
      for (int i = 0; i < HIST; i++) begin
        hist[i]  <= cand[i+1];
        histK[i] <= candK[i+1];
      end
    end
  end

  logic [CNT_W-1:0]  matchCnt;
  logic              startOk;
  logic [WORD_W-1:0] rxWord [COPIES];
  logic [COPIES-1:0] copyAllD;
  logic [COPIES-1:0] copyCrcOk;
  logic [COPIES-1:0] copySame;

  always_comb begin
    matchCnt = '0;
    for (int g = 0; g < START_LEN; g++) begin
      if (candK[g] && cand[g] == START_SET[(START_LEN-1-g)*SYM_W +: SYM_W])
        matchCnt = matchCnt + 1'b1;
    end
  end

  assign startOk = (matchCnt >= CNT_W'(MIN_START_MATCH));

  always_comb begin
    for (int c = 0; c < COPIES; c++) begin
      rxWord[c]   = '0;
      copyAllD[c] = 1'b1;
      for (int b = 0; b < WORD_SYMS; b++) begin
        rxWord[c][(WORD_SYMS-1-b)*SYM_W +: SYM_W] = cand[START_LEN + c*WORD_SYMS + b];
        if (candK[START_LEN + c*WORD_SYMS + b]) copyAllD[c] = 1'b0;
      end
    end
    for (int c = 0; c < COPIES; c++) begin
      copyCrcOk[c] = (crcCalc(rxWord[c][WORD_W-1 -: CMD_W]) == rxWord[c][CRC_W-1:0]);
      copySame[c]  = (rxWord[c] == rxWord[0]);
    end
  end

  assign frameOk = startOk && (&copyAllD) && (&copyCrcOk) && (&copySame);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      cmdOut   <= '0;
    end else begin
      cmdValid <= strb.rxCapture;
      if (strb.rxCapture) cmdOut <= rxWord[0][WORD_W-1 -: CMD_W];
    end
  end

  // R2: the latched word may not change while its frame is on the wire
  assert_word_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.txActive) && strb.txActive) |-> $stable(txWord));

  // R2: once data symbols of a frame begin, no K symbol follows in it
  assert_no_k_after_d_R2: assert property (@(posedge clk) disable iff (!rstN)
    (txSymValid && !txSymIsK) |=> !txSymIsK);
endmodule

// File: rtl/lcmd_link_top.sv
module lcmd_link_top
  import lcmd_pkg::*;
#(
  parameter logic [START_LEN*SYM_W-1:0] START_SET = 32'h5C5C5CF7,
  parameter int MIN_START_MATCH = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txCmdValid,
  output logic             txCmdReady,
  input  logic [CMD_W-1:0] txCmd,
  output logic             txSymValid,
  output logic [SYM_W-1:0] txSymData,
  output logic             txSymIsK,
  input  logic             rxSymValid,
  input  logic [SYM_W-1:0] rxSymData,
  input  logic             rxSymIsK,
  output logic             cmdValid,
  output logic [CMD_W-1:0] cmdOut
);
  lcmdStrobes_t strb;
  logic         frameOk;

  lcmd_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .txCmdValid (txCmdValid),
    .txCmdReady (txCmdReady),
    .rxSymValid (rxSymValid),
    .frameOk    (frameOk),
    .strb       (strb)
  );

  lcmd_datapath #(
    .START_SET       (START_SET),
    .MIN_START_MATCH (MIN_START_MATCH)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .txCmd      (txCmd),
    .txSymValid (txSymValid),
    .txSymData  (txSymData),
    .txSymIsK   (txSymIsK),
    .rxSymData  (rxSymData),
    .rxSymIsK   (rxSymIsK),
    .frameOk    (frameOk),
    .cmdValid   (cmdValid),
    .cmdOut     (cmdOut)
  );

  // R5: a command pulse only follows a cycle in which a symbol was taken
  assert_pulse_after_symbol_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> $past(rxSymValid));
endmodule

// File: tb/lcmd_link_top_tb_top.sv
module lcmd_link_top_tb_top;
  import lcmd_pkg::*;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             txCmdValid = 1'b0;
  logic             txCmdReady;
  logic [CMD_W-1:0] txCmd = '0;
  logic             txSymValid;
  logic [SYM_W-1:0] txSymData;
  logic             txSymIsK;
  logic             rxSymValid = 1'b0;
  logic [SYM_W-1:0] rxSymData = '0;
  logic             rxSymIsK = 1'b0;
  logic             cmdValid;
  logic [CMD_W-1:0] cmdOut;

  always #4 clk = ~clk;

  lcmd_link_top dut_i (
    .clk(clk), .rstN(rstN),
    .txCmdValid(txCmdValid), .txCmdReady(txCmdReady), .txCmd(txCmd),
    .txSymValid(txSymValid), .txSymData(txSymData), .txSymIsK(txSymIsK),
    .rxSymValid(rxSymValid), .rxSymData(rxSymData), .rxSymIsK(rxSymIsK),
    .cmdValid(cmdValid), .cmdOut(cmdOut)
  );

  int total = 0;
  int bad = 0;
  int pulses = 0;
  int expPulses = 0;
  bit finished = 0;

  always @(negedge clk) if (rstN && cmdValid) pulses++;

  function automatic logic [4:0] refCrc(input logic [10:0] c);
    logic [15:0] m;
    m = {c, 5'b0} ^ 16'hF800;
    for (int i = 15; i >= 5; i--)
      if (m[i]) m = m ^ (16'h0025 << (i - 5));
    return ~m[4:0];
  endfunction

  // {isK, byte} of frame symbol k
  function automatic logic [8:0] refSym(input logic [10:0] c, input int k);
    logic [15:0] w;
    w = {c, refCrc(c)};
    case (k)
      0, 1, 2: return {1'b1, 8'h5C};
      3:       return {1'b1, 8'hF7};
      4, 6:    return {1'b0, w[15:8]};
      default: return {1'b0, w[7:0]};
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic txSendCheck(input logic [10:0] c);
    logic [8:0] e;
    @(negedge clk);
    check(txCmdReady == 1'b1, "R4 ready idle", 32'(txCmdReady), 1);
    txCmdValid = 1'b1;
    txCmd = c;
    @(negedge clk);
    txCmdValid = 1'b0;
    txCmd = '0;
    for (int k = 0; k < 8; k++) begin
      if (k > 0) @(negedge clk);
      e = refSym(c, k);
      check(txSymValid && {txSymIsK, txSymData} == e, k < 4 ? "R1 start symbol" : "R2 word symbol",
            32'({txSymValid, txSymIsK, txSymData}), 32'({1'b1, e}));
      check(!txCmdReady, "R4 ready low in frame", 32'(txCmdReady), 0);
      if (k == 5)
        check(txSymData[4:0] == refCrc(c), "R3 crc field", 32'(txSymData[4:0]), 32'(refCrc(c)));
    end
    @(negedge clk);
    check(!txSymValid && txCmdReady, "R1/R4 frame end", 32'({txSymValid, txCmdReady}), 32'h1);
  endtask

  task automatic putSym(input logic [8:0] s);
    @(negedge clk);
    rxSymValid = 1'b1;
    rxSymIsK = s[8];
    rxSymData = s[7:0];
  endtask

  task automatic stallSym();
    @(negedge clk);
    rxSymValid = 1'b0;
    rxSymIsK = 1'($urandom);
    rxSymData = 8'($urandom);
  endtask

  // mode: 0 good, 1 one bad start, 2 two bad start, 3 crc bad, 4 copies differ, 5 K in word
  task automatic rxFrame(input logic [10:0] c, input int mode, input bit stalls, input string req);
    logic [8:0] s [8];
    logic [10:0] c2;
    int p, q, bit_i;
    bit acc;
    for (int k = 0; k < 8; k++) s[k] = refSym(c, k);
    p = int'($urandom % 4);
    case (mode)
      1: begin
        if ($urandom % 2) s[p][8] = 1'b0; else s[p] = s[p] ^ 9'h040;
      end
      2: begin
        q = (p + 1 + int'($urandom % 3)) % 4;
        s[p] = s[p] ^ 9'h040;
        s[q][8] = 1'b0;
      end
      3: begin
        bit_i = int'($urandom % 16);
        if (bit_i >= 8) begin s[4] = s[4] ^ (9'h1 << (bit_i - 8)); s[6] = s[6] ^ (9'h1 << (bit_i - 8)); end
        else            begin s[5] = s[5] ^ (9'h1 << bit_i);       s[7] = s[7] ^ (9'h1 << bit_i); end
      end
      4: begin
        c2 = c ^ (11'd1 + 11'($urandom % 2047));
        s[6] = refSym(c2, 6);
        s[7] = refSym(c2, 7);
      end
      5: s[4 + int'($urandom % 4)][8] = 1'b1;
      default: ;
    endcase
    acc = (mode == 0 || mode == 1);
    for (int k = 0; k < 8; k++) begin
      if (stalls && ($urandom % 3 == 0)) stallSym();
      putSym(s[k]);
    end
    @(negedge clk);
    rxSymValid = 1'b0;
    check(cmdValid == acc, req, 32'(cmdValid), 32'(acc));
    if (acc) begin
      expPulses++;
      check(cmdOut == c, req, 32'(cmdOut), 32'(c));
    end
    @(negedge clk);
    check(cmdValid == 1'b0, "R12 single pulse", 32'(cmdValid), 0);
  endtask

  initial begin
    #(8 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txCmdReady && !txSymValid, "R4 reset state", 32'({txCmdReady, txSymValid}), 32'h2);
    check(!cmdValid, "R12 reset state", 32'(cmdValid), 0);

    // transmit: directed corners then random
    txSendCheck(11'h000);
    txSendCheck(11'h7FF);
    txSendCheck(11'h555);
    for (int i = 0; i < 20; i++) txSendCheck(11'($urandom));

    // receive directed
    rxFrame(11'h000, 0, 0, "R5 good frame");
    rxFrame(11'h7FF, 0, 1, "R12 good frame with stalls");
    rxFrame(11'h123, 1, 0, "R6 one bad start");
    rxFrame(11'h321, 2, 0, "R7 two bad start");
    rxFrame(11'h0F0, 3, 0, "R8 crc bad");
    rxFrame(11'h70F, 4, 0, "R9 copies differ");
    rxFrame(11'h2AA, 5, 0, "R10 K in word");

    // R11: surplus start symbols directly before a good frame
    for (int k = 0; k < 4; k++) putSym(refSym(11'h0, k));
    rxFrame(11'h4C3, 0, 0, "R11 surplus start");
    // R11: rejected frame followed immediately by a good one
    for (int k = 0; k < 8; k++) putSym(k == 1 || k == 2 ? 9'h000 : refSym(11'h1F1, k));
    rxFrame(11'h1F1, 0, 0, "R11 after reject");

    // random mix with junk data symbols between frames
    for (int i = 0; i < 60; i++) begin
      int mode;
      mode = int'($urandom % 6);
      repeat (int'($urandom % 3)) putSym({1'b0, 8'($urandom)});
      case (mode)
        0: rxFrame(11'($urandom), 0, 1, "R5 random good");
        1: rxFrame(11'($urandom), 1, 1, "R6 random one bad start");
        2: rxFrame(11'($urandom), 2, 1, "R7 random two bad start");
        3: rxFrame(11'($urandom), 3, 1, "R8 random crc bad");
        4: rxFrame(11'($urandom), 4, 1, "R9 random copies differ");
        default: rxFrame(11'($urandom), 5, 1, "R10 random K in word");
      endcase
    end

    repeat (4) stallSym();
    @(negedge clk);
    check(pulses == expPulses, "R12 no spurious pulses", 32'(pulses), 32'(expPulses));
    finishRun();
  end
endmodule